// File: doc/BRIEF.md
# Eight-Operation Byte Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit. It takes two byte-wide operands and a three-bit operation code, and it returns one byte-wide result plus two flags. The eight operations are addition, subtraction, doubling of the first operand, an unsigned less-than test, a multiply or divide by four through a fixed shift, reversal of the bit order of the first operand, and two's-complement negation of the second operand.

A single carry-propagate adder handles every arithmetic code. The operation decoder sets up its operand steering, its operand inversion and its carry-in. The shift and reversal paths are plain wiring. An output multiplexer picks the result, and the decoder also decides whether the adder carry is reported. The enclosing datapath places the block between its operand registers and its result register, so all outputs follow the inputs within the same cycle.

Top module: `eight_op_alu`

## Requirements
- R1: Code 3'b000 gives result = (A + B) mod 256, and carry_out equals bit 8 of the 9-bit sum.
- R2: Code 3'b001 gives result = (A − B) mod 256, and carry_out is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R3: Code 3'b010 gives result = (2·A) mod 256, and carry_out equals A bit 7.
- R4: Code 3'b011 gives result 8'h01 when A < B as unsigned numbers and 8'h00 otherwise.
- R5: Code 3'b100 gives result = (4·A) mod 256, a logical left shift by two that drops the two top bits.
- R6: Code 3'b101 gives result = floor(A / 4), a logical right shift by two that fills the top with zeros.
- R7: Code 3'b110 gives A with its bit order reversed: result bit i equals A bit 7−i.
- R8: Code 3'b111 gives result = (256 − B) mod 256, the two's complement of B.
- R9: zero_flag is 1 exactly when the 8-bit result is all zeros, for every code.
- R10: carry_out is 0 for every code from 3'b011 through 3'b111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand |
| op_sel | input | 3 | Operation code; bit 2 is the most significant |
| result | output | 8 | Selected operation result |
| carry_out | output | 1 | Adder carry for codes 000 to 010; 0 otherwise |
| zero_flag | output | 1 | High when result is all zeros |

## Verification
The bench builds the block with its default byte width and a shift distance of two. At that size the whole input space is small enough to sweep: all 65,536 operand pairs under each of the eight codes. This covers every carry and borrow boundary, the A = B tie in the compare, the negation of zero and of 8'h80, and every bit pattern through the reversal and shift paths. Each expected result and flag is computed with integer arithmetic in the bench.

// File: rtl/eight_op_alu_pkg.sv
package eight_op_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_DBL  = 3'b010,
    OP_LT   = 3'b011,
    OP_MUL4 = 3'b100,
    OP_DIV4 = 3'b101,
    OP_REV  = 3'b110,
    OP_NEG  = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_SUM = 3'd0,
    SEL_LT  = 3'd1,
    SEL_SHL = 3'd2,
    SEL_SHR = 3'd3,
    SEL_REV = 3'd4
  } res_sel_e;

  typedef struct packed {
    logic     opa_zero;    // first adder operand forced to zero
    logic     opb_from_a;  // second adder operand taken from A
    logic     opb_invert;  // second adder operand inverted
    logic     carry_in;    // adder carry-in
    logic     carry_keep;  // adder carry reported on carry_out
    res_sel_e res_sel;     // output multiplexer select
  } alu_ctl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import eight_op_alu_pkg::*;
(
  input  logic [2:0] op_code,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl            = '0;
    ctl.res_sel    = SEL_SUM;
    case (op_code)
      OP_ADD: begin
        ctl.carry_keep = 1'b1;
      end
      OP_SUB: begin
        ctl.opb_invert = 1'b1;
        ctl.carry_in   = 1'b1;
        ctl.carry_keep = 1'b1;
      end
      OP_DBL: begin
        ctl.opb_from_a = 1'b1;
        ctl.carry_keep = 1'b1;
      end
      OP_LT: begin
        ctl.opb_invert = 1'b1;
        ctl.carry_in   = 1'b1;
        ctl.res_sel    = SEL_LT;
      end
      OP_MUL4: ctl.res_sel = SEL_SHL;
      OP_DIV4: ctl.res_sel = SEL_SHR;
      OP_REV:  ctl.res_sel = SEL_REV;
      OP_NEG: begin
        ctl.opa_zero   = 1'b1;
        ctl.opb_invert = 1'b1;
        ctl.carry_in   = 1'b1;
      end
      default: ctl.res_sel = SEL_SUM;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic              opa_zero,
  input  logic              opb_from_a,
  input  logic              opb_invert,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb_raw;
  logic [DATA_W-1:0] opb;
  logic [SUM_W-1:0]  total;

  always_comb begin
    opa     = opa_zero   ? '0    : a_val;
    opb_raw = opb_from_a ? a_val : b_val;
    opb     = opb_invert ? ~opb_raw : opb_raw;
    total   = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, carry_in};
    sum     = total[DATA_W-1:0];
    cout    = total[SUM_W-1];
  end

endmodule

// File: rtl/alu_shift_rev.sv
module alu_shift_rev #(
  parameter int DATA_W    = 8,
  parameter int SHIFT_AMT = 2
) (
  input  logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] shl,
  output logic [DATA_W-1:0] shr,
  output logic [DATA_W-1:0] rev
);

  localparam int TOP = DATA_W - 1;

  assign shl = a_val << SHIFT_AMT;
  assign shr = a_val >> SHIFT_AMT;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = a_val[TOP-i];
  end

endmodule

// File: rtl/eight_op_alu.sv
module eight_op_alu
  import eight_op_alu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SHIFT_AMT = 2
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [2:0]        op_sel,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              zero_flag
);

  localparam int PAD_W = DATA_W - 1;

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] shr;
  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] chk_back;

  alu_op_decode u_decode (
    .op_code (op_sel),
    .ctl     (ctl)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_val      (a_in),
    .b_val      (b_in),
    .opa_zero   (ctl.opa_zero),
    .opb_from_a (ctl.opb_from_a),
    .opb_invert (ctl.opb_invert),
    .carry_in   (ctl.carry_in),
    .sum        (sum),
    .cout       (cout)
  );

  alu_shift_rev #(.DATA_W(DATA_W), .SHIFT_AMT(SHIFT_AMT)) u_shift (
    .a_val (a_in),
    .shl   (shl),
    .shr   (shr),
    .rev   (rev)
  );

  always_comb begin
    case (ctl.res_sel)
      SEL_SUM: result = sum;
      SEL_LT:  result = {{PAD_W{1'b0}}, ~cout};
      SEL_SHL: result = shl;
      SEL_SHR: result = shr;
      SEL_REV: result = rev;
      default: result = sum;
    endcase
  end

  assign carry_out = ctl.carry_keep & cout;
  assign zero_flag = ~|result;

  // Adding B back onto the result recovers A for subtract and zero for negate.
  assign chk_back = result + b_in;

  always_comb begin
    if (op_sel == OP_SUB)
      assert_sub_inverse_R2: assert (chk_back == a_in);
    if (op_sel == OP_NEG)
      assert_neg_cancels_R8: assert (chk_back == '0);
    if (op_sel == OP_LT)
      assert_lt_boolean_R4: assert (result[DATA_W-1:1] == '0);
    if (op_sel == OP_DBL)
      assert_dbl_carry_R3: assert (result[0] == 1'b0 && carry_out == a_in[DATA_W-1]);
    if (op_sel == OP_MUL4)
      assert_shl_low_clear_R5: assert (result[SHIFT_AMT-1:0] == '0);
    if (op_sel == OP_DIV4)
      assert_shr_top_clear_R6: assert (result[DATA_W-1:DATA_W-SHIFT_AMT] == '0);
    if (op_sel[2] || op_sel == OP_LT)
      assert_carry_quiet_R10: assert (carry_out == 1'b0);
    if (zero_flag)
      assert_zero_result_R9: assert (result == '0);
  end

endmodule

// File: tb/tb_eight_op_alu.sv
module tb_eight_op_alu;

  logic       clk = 1'b0;
  logic [7:0] a_in;
  logic [7:0] b_in;
  logic [2:0] op_sel;
  logic [7:0] result;
  logic       carry_out;
  logic       zero_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  eight_op_alu dut (
    .a_in      (a_in),
    .b_in      (b_in),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .zero_flag (zero_flag)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, op_sel, a_in, b_in, act, exp);
    end
  endtask

  function automatic int reverse_byte(int v);
    int r = 0;
    int x = v;
    for (int i = 0; i < 8; i++) begin
      r = r * 2 + (x % 2);
      x = x / 2;
    end
    return r;
  endfunction

  initial begin
    string res_tag [8];
    res_tag[0] = "R1"; res_tag[1] = "R2"; res_tag[2] = "R3"; res_tag[3] = "R4";
    res_tag[4] = "R5"; res_tag[5] = "R6"; res_tag[6] = "R7"; res_tag[7] = "R8";

    // Idle state: zero operands under code 000.
    a_in = 8'd0; b_in = 8'd0; op_sel = 3'd0;
    #3;
    check("R1 idle result", int'(result), 0);
    check("R9 idle zero", int'(zero_flag), 1);
    check("R1 idle carry", int'(carry_out), 0);

    for (int op = 0; op < 8; op++) begin
      for (int ia = 0; ia < 256; ia++) begin
        for (int ib = 0; ib < 256; ib++) begin
          int exp_r;
          int exp_c;
          a_in   = 8'(ia);
          b_in   = 8'(ib);
          op_sel = 3'(op);
          #1;
          exp_c = 0;
          case (op)
            0: begin exp_r = (ia + ib) % 256;       exp_c = (ia + ib) / 256; end
            1: begin exp_r = (ia - ib + 256) % 256; exp_c = (ia >= ib) ? 1 : 0; end
            2: begin exp_r = (2 * ia) % 256;        exp_c = (ia >= 128) ? 1 : 0; end
            3: exp_r = (ia < ib) ? 1 : 0;
            4: exp_r = (4 * ia) % 256;
            5: exp_r = ia / 4;
            6: exp_r = reverse_byte(ia);
            default: exp_r = (256 - ib) % 256;
          endcase
          check(res_tag[op], int'(result), exp_r);
          check((op >= 3) ? "R10 carry" : res_tag[op], int'(carry_out), exp_c);
          check("R9 zero flag", int'(zero_flag), (exp_r == 0) ? 1 : 0);
          #1;
        end
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule